// File: doc/BRIEF.md
# Stack Operand Tag Renamer

This block sits at the front of an out-of-order back end for a zero-operand stack instruction set. Each incoming instruction names only an operation kind and a function code, because its operands are implied by stack position. The block keeps a mapping stack whose entries are tags, not values. Any instruction that makes a result draws a fresh tag from a free pool. Any instruction that consumes values pops the tags that stand for its sources. What leaves the block is an execution package: the function code, up to two source tags and a destination tag. The stack encoding is gone from it.

Tags go back to the pool through a release port when the owning result is written back. A flush input wipes the mapping stack and refills the pool in one cycle, for use after a misprediction or a trap.

The instruction input and the package output are valid/ready streams. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is computed for the instruction currently presented, and it stays low while that instruction cannot be renamed in full. The output holds one package. While `out_valid` is high and `out_ready` is low, the package stays unchanged and any instruction that would emit a package waits.

Top module: `stk_tag_renamer`

## Requirements
- R1: A push-constant (`in_op` = 2'b00) takes the lowest-numbered free tag, pushes it on the mapping stack, and emits a package whose destination is that tag, with source count 0 and both source tags 0.
- R2: A binary operation (`in_op` = 2'b11) emits a package with source count 2. Source 0 is the tag one below the top and source 1 is the top tag. Both are popped, and the newly allocated lowest free tag is pushed and becomes the destination.
- R3: A unary operation (`in_op` = 2'b10) emits a package with source count 1, source 0 equal to the top tag and source 1 equal to 0. The top entry is replaced by the newly allocated lowest free tag, which is also the destination.
- R4: A discard (`in_op` = 2'b01) removes the top tag, allocates nothing and emits no package.
- R5: When the pool holds no free tag, `in_ready` is low for push, unary and binary, and the stack and pool do not change.
- R6: When the instruction would pop more entries than the stack holds, `in_ready` is low and no state changes.
- R7: A push-constant presented while the stack holds 16 entries sees `in_ready` low, and the depth never exceeds 16.
- R8: A tag presented on the release port becomes allocatable from the next cycle, and allocation always prefers the lowest number.
- R9: While `flush` is high, `in_ready` is low. After it, the stack is empty, all 32 tags are free and `out_valid` is low.
- R10: While `out_valid` is high and `out_ready` is low, the package fields stay stable and instructions that emit a package see `in_ready` low. A discard is still accepted.
- R11: After reset the stack is empty, all tags are free and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the mapping stack and free every tag |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction can be renamed this cycle |
| in_op | input | 2 | Kind: 00 push, 01 discard, 10 unary, 11 binary |
| in_func | input | 4 | Function code carried into the package |
| out_valid | output | 1 | Package present |
| out_ready | input | 1 | Consumer takes the package |
| out_func | output | 4 | Function code of the package |
| out_src_cnt | output | 2 | Number of meaningful source tags |
| out_src0 | output | 5 | First source tag |
| out_src1 | output | 5 | Second source tag (the former top for binary) |
| out_dst | output | 5 | Destination tag |
| rel_valid | input | 1 | Release request |
| rel_tag | input | 5 | Tag being released |

## Verification
The hardest condition to reach from the ports is an empty tag pool while the mapping stack is far from full. A stack of 16 holds only half the tags, so the pool runs dry only if tags pile up in flight. The stimulus fills the stack with sixteen pushes and then folds it down with fifteen binary operations and one unary, with no release. That uses all 32 tags with one entry left on the stack. A push is then held against the stall for several cycles before selected releases bring specific tags back. After that, a long mixed sweep interleaves releases, output back-pressure and a flush, and checks each step against a behavioural model of the stack and pool.

// File: rtl/stk_ren_pkg.sv
package stk_ren_pkg;

  typedef enum logic [1:0] {
    OPK_PUSH   = 2'b00,
    OPK_DROP   = 2'b01,
    OPK_UNARY  = 2'b10,
    OPK_BINARY = 2'b11
  } opkind_e;

  // number of mapping-stack entries an operation kind consumes
  function automatic logic [1:0] pops_of(opkind_e k);
    case (k)
      OPK_PUSH:   pops_of = 2'd0;
      OPK_DROP:   pops_of = 2'd1;
      OPK_UNARY:  pops_of = 2'd1;
      default:    pops_of = 2'd2;
    endcase
  endfunction

  // every kind except discard produces a value and therefore a package
  function automatic logic makes_value(opkind_e k);
    makes_value = (k != OPK_DROP);
  endfunction

endpackage

// File: rtl/tag_free_pool.sv
module tag_free_pool #(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_en,
  input  logic             rel_en,
  input  logic [TAG_W-1:0] rel_tag,
  output logic [TAG_W-1:0] alloc_tag,
  output logic             any_free
);
  localparam int NUM_TAGS = 1 << TAG_W;

  logic [NUM_TAGS-1:0] free_q;
  logic [NUM_TAGS-1:0] free_d;

  // lowest-numbered free tag wins
  always_comb begin
    alloc_tag = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_tag = TAG_W'(i);
    end
  end

  assign any_free = |free_q;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_bit
    logic take, give;
    assign take = alloc_en && (alloc_tag == TAG_W'(g));
    assign give = rel_en && (rel_tag == TAG_W'(g));
    assign free_d[g] = flush | give | (free_q[g] & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end

endmodule

// File: rtl/tag_map_stack.sv
module tag_map_stack #(
  parameter int STACK_DEPTH = 16,
  parameter int TAG_W       = 5,
  localparam int CNT_W      = $clog2(STACK_DEPTH + 1),
  localparam int IDX_W      = $clog2(STACK_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [1:0]       pop_cnt,
  input  logic             push_en,
  input  logic [TAG_W-1:0] push_tag,
  output logic [CNT_W-1:0] depth,
  output logic [TAG_W-1:0] tos,
  output logic [TAG_W-1:0] nos
);
  logic [TAG_W-1:0] ent_q [STACK_DEPTH];
  logic [CNT_W-1:0] depth_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] tos_idx;
  logic [CNT_W-1:0] nos_idx;

  assign depth   = depth_q;
  assign base    = depth_q - CNT_W'(pop_cnt);
  assign tos_idx = depth_q - CNT_W'(1);
  assign nos_idx = depth_q - CNT_W'(2);

  assign tos = (depth_q >= CNT_W'(1)) ? ent_q[tos_idx[IDX_W-1:0]] : '0;
  assign nos = (depth_q >= CNT_W'(2)) ? ent_q[nos_idx[IDX_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) ent_q[i] <= '0;
    end else if (flush) begin
      depth_q <= '0;
    end else begin
      depth_q <= base + CNT_W'(push_en);
      if (push_en) ent_q[base[IDX_W-1:0]] <= push_tag;
    end
  end

endmodule

// File: rtl/tag_pkt_reg.sv
module tag_pkt_reg #(
  parameter int TAG_W  = 5,
  parameter int FUNC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [FUNC_W-1:0] ld_func,
  input  logic [1:0]        ld_cnt,
  input  logic [TAG_W-1:0]  ld_src0,
  input  logic [TAG_W-1:0]  ld_src1,
  input  logic [TAG_W-1:0]  ld_dst,
  output logic              space,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FUNC_W-1:0] out_func,
  output logic [1:0]        out_cnt,
  output logic [TAG_W-1:0]  out_src0,
  output logic [TAG_W-1:0]  out_src1,
  output logic [TAG_W-1:0]  out_dst
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_func  <= '0;
      out_cnt   <= '0;
      out_src0  <= '0;
      out_src1  <= '0;
      out_dst   <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_func  <= ld_func;
      out_cnt   <= ld_cnt;
      out_src0  <= ld_src0;
      out_src1  <= ld_src1;
      out_dst   <= ld_dst;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/stk_tag_renamer.sv
module stk_tag_renamer
  import stk_ren_pkg::*;
#(
  parameter int STACK_DEPTH = 16,
  parameter int TAG_W       = 5,
  parameter int FUNC_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [FUNC_W-1:0] in_func,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FUNC_W-1:0] out_func,
  output logic [1:0]        out_src_cnt,
  output logic [TAG_W-1:0]  out_src0,
  output logic [TAG_W-1:0]  out_src1,
  output logic [TAG_W-1:0]  out_dst,
  input  logic              rel_valid,
  input  logic [TAG_W-1:0]  rel_tag
);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);

  opkind_e          kind;
  logic [1:0]       pops;
  logic             need_tag;
  logic             underflow, overflow, no_tag, out_blocked;
  logic             fire;
  logic [CNT_W-1:0] stk_depth;
  logic [TAG_W-1:0] stk_tos, stk_nos;
  logic [TAG_W-1:0] new_tag;
  logic             pool_any_free;
  logic             out_space;
  logic [TAG_W-1:0] pk_src0, pk_src1;

  assign kind     = opkind_e'(in_op);
  assign pops     = pops_of(kind);
  assign need_tag = makes_value(kind);

  assign underflow   = CNT_W'(pops) > stk_depth;
  assign overflow    = (kind == OPK_PUSH) && (stk_depth == CNT_W'(STACK_DEPTH));
  assign no_tag      = need_tag && !pool_any_free;
  assign out_blocked = need_tag && !out_space;

  assign in_ready = !flush && !underflow && !overflow && !no_tag && !out_blocked;
  assign fire     = in_valid && in_ready;

  always_comb begin
    pk_src0 = '0;
    pk_src1 = '0;
    if (kind == OPK_BINARY) begin
      pk_src0 = stk_nos;
      pk_src1 = stk_tos;
    end else if (kind == OPK_UNARY) begin
      pk_src0 = stk_tos;
    end
  end

  tag_free_pool #(.TAG_W(TAG_W)) pool_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .alloc_en  (fire && need_tag),
    .rel_en    (rel_valid),
    .rel_tag   (rel_tag),
    .alloc_tag (new_tag),
    .any_free  (pool_any_free)
  );

  tag_map_stack #(.STACK_DEPTH(STACK_DEPTH), .TAG_W(TAG_W)) stk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .pop_cnt  (fire ? pops : 2'd0),
    .push_en  (fire && need_tag),
    .push_tag (new_tag),
    .depth    (stk_depth),
    .tos      (stk_tos),
    .nos      (stk_nos)
  );

  tag_pkt_reg #(.TAG_W(TAG_W), .FUNC_W(FUNC_W)) pkt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .load      (fire && need_tag),
    .ld_func   (in_func),
    .ld_cnt    ((kind == OPK_PUSH) ? 2'd0 : pops),
    .ld_src0   (pk_src0),
    .ld_src1   (pk_src1),
    .ld_dst    (new_tag),
    .space     (out_space),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_func  (out_func),
    .out_cnt   (out_src_cnt),
    .out_src0  (out_src0),
    .out_src1  (out_src1),
    .out_dst   (out_dst)
  );

endmodule

// File: rtl/stk_ren_chk.sv
module stk_ren_chk #(
  parameter int STACK_DEPTH = 16,
  parameter int TAG_W       = 5,
  parameter int FUNC_W      = 4,
  localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FUNC_W-1:0] out_func,
  input logic [1:0]        out_src_cnt,
  input logic [TAG_W-1:0]  out_src0,
  input logic [TAG_W-1:0]  out_src1,
  input logic [TAG_W-1:0]  out_dst,
  input logic [CNT_W-1:0]  depth,
  input logic              any_free
);

  p_hold_pkt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_dst) &&
      $stable(out_src0) && $stable(out_src1) && $stable(out_src_cnt) && $stable(out_func)));

  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && depth == '0));

  p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  p_depth_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(STACK_DEPTH));

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_op == 2'b11 && depth < CNT_W'(2)) |-> !in_ready);

  p_pool_dry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_op != 2'b01 && !any_free) |-> !in_ready);

  p_drop_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'b01 && out_ready) |=> !out_valid);

endmodule

bind stk_tag_renamer stk_ren_chk #(
  .STACK_DEPTH (STACK_DEPTH),
  .TAG_W       (TAG_W),
  .FUNC_W      (FUNC_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_func    (out_func),
  .out_src_cnt (out_src_cnt),
  .out_src0    (out_src0),
  .out_src1    (out_src1),
  .out_dst     (out_dst),
  .depth       (stk_depth),
  .any_free    (pool_any_free)
);

// File: tb/stk_tag_renamer_tb_top.sv
module stk_tag_renamer_tb_top;

  localparam logic [1:0] OP_PUSH = 2'b00;
  localparam logic [1:0] OP_DROP = 2'b01;
  localparam logic [1:0] OP_UN   = 2'b10;
  localparam logic [1:0] OP_BIN  = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_op = 2'b00;
  logic [3:0] in_func = 4'd0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [3:0] out_func;
  logic [1:0] out_src_cnt;
  logic [4:0] out_src0, out_src1, out_dst;
  logic       rel_valid = 1'b0;
  logic [4:0] rel_tag = 5'd0;

  always #4 clk = ~clk;

  stk_tag_renamer dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_func(in_func),
    .out_valid(out_valid), .out_ready(out_ready), .out_func(out_func),
    .out_src_cnt(out_src_cnt), .out_src0(out_src0), .out_src1(out_src1),
    .out_dst(out_dst), .rel_valid(rel_valid), .rel_tag(rel_tag)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model of the requirements
  int          mdepth = 0;
  logic [4:0]  mstk [16];
  logic [31:0] mfree = '1;
  bit          mout_valid = 0;
  logic [3:0]  mo_func;
  logic [1:0]  mo_cnt;
  logic [4:0]  mo_src0, mo_src1, mo_dst;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] lowest_free();
    for (int i = 0; i < 32; i++) if (mfree[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic check_out(input string req);
    chk(out_valid == mout_valid, req, "out_valid", int'(out_valid), int'(mout_valid));
    if (mout_valid)
      chk({out_func, out_src_cnt, out_src0, out_src1, out_dst} ==
          {mo_func, mo_cnt, mo_src0, mo_src1, mo_dst}, req, "package",
          int'({out_func, out_src_cnt, out_src0, out_src1, out_dst}),
          int'({mo_func, mo_cnt, mo_src0, mo_src1, mo_dst}));
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic do_op(input logic [1:0] op, input logic [3:0] fn, input string req);
    int pops;
    bit mk, exp_rdy;
    logic [4:0] t;
    pops = (op == OP_BIN) ? 2 : ((op == OP_PUSH) ? 0 : 1);
    mk = (op != OP_DROP);
    exp_rdy = 1;
    if (pops > mdepth) exp_rdy = 0;
    if (op == OP_PUSH && mdepth == 16) exp_rdy = 0;
    if (mk && mfree == 0) exp_rdy = 0;
    if (mk && mout_valid && !out_ready) exp_rdy = 0;
    in_valid = 1'b1; in_op = op; in_func = fn;
    #1;
    chk(in_ready == exp_rdy, req, "in_ready", int'(in_ready), int'(exp_rdy));
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (exp_rdy && mk) begin
      t = lowest_free();
      mfree[t] = 1'b0;
      mo_func = fn; mo_dst = t; mo_src0 = '0; mo_src1 = '0;
      mo_cnt = 2'(pops);
      if (op == OP_UN) mo_src0 = mstk[mdepth-1];
      if (op == OP_BIN) begin
        mo_src0 = mstk[mdepth-2];
        mo_src1 = mstk[mdepth-1];
      end
      mdepth = mdepth - pops;
      mstk[mdepth] = t;
      mdepth++;
      mout_valid = 1;
    end else begin
      if (exp_rdy) mdepth = mdepth - pops;
      mout_valid = mout_valid && !out_ready;
    end
    @(negedge clk);
    check_out(req);
  endtask

  task automatic do_rel(input logic [4:0] t);
    rel_valid = 1'b1; rel_tag = t;
    @(posedge clk); #1;
    rel_valid = 1'b0;
    mfree[t] = 1'b1;
    mout_valid = mout_valid && !out_ready;
    @(negedge clk);
    check_out("R8");
  endtask

  task automatic do_flush();
    flush = 1'b1; in_valid = 1'b1; in_op = OP_PUSH;
    #1;
    chk(in_ready == 1'b0, "R9", "in_ready during flush", int'(in_ready), 0);
    @(posedge clk); #1;
    flush = 1'b0; in_valid = 1'b0;
    mdepth = 0; mfree = '1; mout_valid = 0;
    @(negedge clk);
    check_out("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
    @(negedge clk);
    // R6: pops from an empty stack stall
    do_op(OP_DROP, 4'd0, "R6");
    do_op(OP_UN,   4'd0, "R6");
    do_op(OP_BIN,  4'd0, "R6");
    // R1: fill the stack, tags 0..15 in order (R11 all tags free)
    for (int i = 0; i < 16; i++) do_op(OP_PUSH, 4'(i), "R1");
    // R7: full stack refuses a push
    do_op(OP_PUSH, 4'd3, "R7");
    // R2: fold down, tags 16..30
    for (int i = 0; i < 15; i++) do_op(OP_BIN, 4'(i), "R2");
    // R3: unary on the last entry takes tag 31
    do_op(OP_UN, 4'd9, "R3");
    // R5: pool empty, held for several cycles
    for (int i = 0; i < 4; i++) do_op(OP_PUSH, 4'd1, "R5");
    do_op(OP_UN, 4'd1, "R5");
    // R8: released tags come back lowest first
    do_rel(5'd7);
    do_rel(5'd3);
    do_op(OP_PUSH, 4'd2, "R8");
    do_op(OP_PUSH, 4'd4, "R8");
    do_op(OP_PUSH, 4'd5, "R5");
    // R4: discard takes no tag and emits nothing
    do_op(OP_DROP, 4'd0, "R4");
    do_op(OP_BIN,  4'd6, "R5");
    do_op(OP_DROP, 4'd0, "R4");
    do_rel(5'd20);
    do_op(OP_BIN,  4'd6, "R6");
    do_op(OP_PUSH, 4'd7, "R8");
    // R10: back-pressure on the output
    do_rel(5'd0);
    do_rel(5'd1);
    out_ready = 1'b0;
    do_op(OP_PUSH, 4'd8, "R10");
    do_op(OP_PUSH, 4'd8, "R10");
    do_op(OP_DROP, 4'd0, "R10");
    out_ready = 1'b1;
    do_op(OP_PUSH, 4'd8, "R10");
    do_op(OP_BIN,  4'd8, "R2");
    // R9: flush empties everything
    do_flush();
    do_op(OP_DROP, 4'd0, "R9");
    do_op(OP_PUSH, 4'd1, "R9");
    // mixed sweep against the model
    for (int i = 0; i < 600; i++) begin
      out_ready = (i % 5 != 0);
      if (i % 3 == 0) do_rel(5'((i * 11) % 32));
      if (i == 300) do_flush();
      do_op(2'((i * 5 + i / 7) % 4), 4'(i % 16), "R1/R2/R3/R4 sweep");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule